// File: doc/BRIEF.md
# Byte-Accessed Up/Down Counter

This block holds a 16-bit counter that a host reaches over an 8-bit bus. Each timer tick can clear the counter, add one to it or subtract one from it. The bus sees the count as a low byte and a high byte. A shared temporary byte register makes both 16-bit reads and 16-bit writes atomic:

- Reading the low byte snapshots the high half into the temporary register. A later read of the high address returns that snapshot.
- Writing the high address only fills the temporary register. A later write of the low byte commits both halves in one cycle.

Ticks pass only when the 3-bit clock-select code is nonzero and the tick enable is high. With code 0 the counter holds, but bus access still works. A bus write to the counter takes priority over any clear or count in the same cycle.

The block decodes the count into two outputs: one for zero and one for a maximum value given on an input. An overflow flag is set when an up-count wraps from that maximum to zero. The flag drives an interrupt request and stays set until the host clears it.

The counter's next action is decoded each cycle into one of seven named actions, checked in this order:

- LOAD: a bus write to the low byte.
- HOLD: no tick.
- CLEAR: a tick with the clear input high.
- UP: a tick counting up below the maximum.
- WRAP_UP: a tick counting up at the maximum, to zero.
- DOWN: a tick counting down above zero.
- WRAP_DN: a tick counting down at zero, to the maximum.

The tick gate has two named states: STOP when the code is 0 (or masked off), and RUN otherwise.

Top module: `byte_updown_counter`

## Requirements
- R1: After reset the counter, the temporary register and the overflow flag are all zero, so at_bottom=1, at_top=0 and ovf_flag=0 (with top_val nonzero).
- R2: A bus read of address 0 returns the counter's low byte combinationally. On the same edge it copies the counter's high byte into the temporary register. A read of address 1 returns the temporary register, so the two reads give one consistent 16-bit value even while the counter ticks between them.
- R3: A bus write to address 1 loads the temporary register only. The counter does not change until the next write to address 0.
- R4: A bus write to address 0 loads the counter with {temporary register, bus byte} on one edge.
- R5: A bus write to address 0 overrides any clear or count action in the same cycle.
- R6: On a tick, clr_req=1 sets the counter to zero whatever the direction. Otherwise dir_down=0 adds one and dir_down=1 subtracts one.
- R7: With clk_sel=0 no tick occurs and the counter holds even when tick_en=1, while bus reads and writes still work. Any nonzero clk_sel passes tick_en.
- R8: at_bottom is 1 exactly when the count is zero, and at_top is 1 exactly when the count equals top_val. Both follow the count with no added delay.
- R9: An up tick at count == top_val wraps the count to zero and sets ovf_flag. A down tick at zero wraps the count to top_val without setting ovf_flag.
- R10: ovf_flag stays set until a bus write to address 2 with data bit 0 equal to 1. A write there with bit 0 equal to 0 leaves it set. If the flag is set and cleared in the same cycle, setting wins. A read of address 2 returns the flag in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | 0 low byte, 1 high/temporary byte, 2 flag |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (read of address 0 takes the snapshot) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current address |
| clk_sel | input | 3 | Clock-select code, 0 stops counting |
| tick_en | input | 1 | Timer tick enable |
| dir_down | input | 1 | 1 counts down, 0 counts up |
| clr_req | input | 1 | Clear on the next tick |
| top_val | input | 16 | Configured maximum count |
| at_top | output | 1 | Count equals top_val |
| at_bottom | output | 1 | Count is zero |
| ovf_flag | output | 1 | Overflow flag / interrupt request |

## Verification
Counter changes, temporary-register loads and flag changes happen on the first rising edge after the inputs are applied. The bench therefore drives on the falling edge and observes one falling edge later.

bus_rdata, at_top and at_bottom are combinational from the stored state. They are sampled 1 ns after the inputs are driven, in the same half-cycle.

The atomic-read case keeps ticks running across the two byte reads. The expected value is the count at the low-byte read, not the count at the high-byte read. All expected values are computed in the driver and queued for the monitor, which pairs them with observed values in order.

// File: rtl/cntr_pkg.sv
`timescale 1ns/1ps
package cntr_pkg;

    // Bus register selection; the address value is what the host drives.
    typedef enum logic [1:0] {
        ADR_LO   = 2'd0,
        ADR_HI   = 2'd1,
        ADR_FLG  = 2'd2,
        ADR_NONE = 2'd3
    } adr_e;

    // Per-cycle action taken by the counter.
    typedef enum logic [2:0] {
        ACT_HOLD    = 3'd0,
        ACT_LOAD    = 3'd1,
        ACT_CLEAR   = 3'd2,
        ACT_UP      = 3'd3,
        ACT_WRAP_UP = 3'd4,
        ACT_DOWN    = 3'd5,
        ACT_WRAP_DN = 3'd6
    } act_e;

    // Tick gate state derived from the clock-select code.
    typedef enum logic {
        GATE_STOP = 1'b0,
        GATE_RUN  = 1'b1
    } gate_e;

endpackage

// File: rtl/cntr_tick_sel.sv
`timescale 1ns/1ps
module cntr_tick_sel
    import cntr_pkg::*;
#(
    parameter int SEL_W = 3,
    parameter logic [(1<<SEL_W)-1:0] SEL_MASK = '1
) (
    input  logic [SEL_W-1:0] clk_sel,
    input  logic             tick_en,
    output logic             tick
);
    localparam int NCODE = 1 << SEL_W;

    logic [NCODE-1:0] code_ok;
    gate_e            gate;

    // Code 0 always stops; other codes pass according to the mask.
    genvar k;
    generate
        for (k = 0; k < NCODE; k++) begin : g_code
            if (k == 0) begin : g_stop
                assign code_ok[k] = 1'b0;
            end else begin : g_pass
                assign code_ok[k] = SEL_MASK[k];
            end
        end
    endgenerate

    always_comb begin
        gate = code_ok[clk_sel] ? GATE_RUN : GATE_STOP;
    end

    always_comb begin
        unique case (gate)
            GATE_STOP: tick = 1'b0;
            GATE_RUN:  tick = tick_en;
            default:   tick = 1'b0;
        endcase
    end

endmodule

// File: rtl/cntr_core.sv
`timescale 1ns/1ps
module cntr_core
    import cntr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             dir_down,
    input  logic             clr_req,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] top_val,
    output logic [CNT_W-1:0] count,
    output logic             at_top,
    output logic             at_bottom,
    output logic             wrap_evt
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;
    act_e             act;

    // Action decode: bus load, then tick gating, then clear, then direction.
    always_comb begin
        if (load)
            act = ACT_LOAD;
        else if (!tick)
            act = ACT_HOLD;
        else if (clr_req)
            act = ACT_CLEAR;
        else if (!dir_down)
            act = (cnt_q == top_val) ? ACT_WRAP_UP : ACT_UP;
        else
            act = (cnt_q == '0) ? ACT_WRAP_DN : ACT_DOWN;
    end

    always_comb begin
        unique case (act)
            ACT_HOLD:    cnt_nxt = cnt_q;
            ACT_LOAD:    cnt_nxt = load_val;
            ACT_CLEAR:   cnt_nxt = '0;
            ACT_UP:      cnt_nxt = cnt_q + 1'b1;
            ACT_WRAP_UP: cnt_nxt = '0;
            ACT_DOWN:    cnt_nxt = cnt_q - 1'b1;
            ACT_WRAP_DN: cnt_nxt = top_val;
            default:     cnt_nxt = cnt_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_nxt;
    end

    always_comb begin
        count     = cnt_q;
        at_top    = (cnt_q == top_val);
        at_bottom = (cnt_q == '0);
        wrap_evt  = (act == ACT_WRAP_UP);
    end

    // R5
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (count == $past(load_val)));

    // R7
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !tick) |=> $stable(count));

    // R6
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && tick && clr_req) |=> (count == '0));

    // R9
    up_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && tick && !clr_req && !dir_down && count == top_val) |=> (count == '0));

    // R9
    down_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && tick && !clr_req && dir_down && count == '0) |=> (count == $past(top_val)));

endmodule

// File: rtl/cntr_byte_port.sv
`timescale 1ns/1ps
module cntr_byte_port
    import cntr_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int CNT_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic [CNT_W-1:0]  count,
    input  logic              wrap_evt,
    output logic              load,
    output logic [CNT_W-1:0]  load_val,
    output logic              ovf_flag
);
    adr_e              sel;
    logic [BYTE_W-1:0] temp_q;
    logic              ovf_q;
    logic              flag_clr;

    always_comb begin
        sel      = adr_e'(bus_addr);
        load     = bus_wr && (sel == ADR_LO);
        load_val = {temp_q, bus_wdata};
        flag_clr = bus_wr && (sel == ADR_FLG) && bus_wdata[0];
    end

    // Shared temporary byte: written by high-address writes,
    // refreshed from the counter by low-byte reads.
    always_ff @(posedge clk) begin
        if (!rst_n)
            temp_q <= '0;
        else if (bus_wr && sel == ADR_HI)
            temp_q <= bus_wdata;
        else if (bus_rd && sel == ADR_LO)
            temp_q <= count[CNT_W-1:BYTE_W];
    end

    // Sticky overflow flag; a set in the same cycle beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovf_q <= 1'b0;
        else if (wrap_evt)
            ovf_q <= 1'b1;
        else if (flag_clr)
            ovf_q <= 1'b0;
    end

    always_comb begin
        unique case (sel)
            ADR_LO:   bus_rdata = count[BYTE_W-1:0];
            ADR_HI:   bus_rdata = temp_q;
            ADR_FLG:  bus_rdata = {{(BYTE_W-1){1'b0}}, ovf_q};
            ADR_NONE: bus_rdata = '0;
            default:  bus_rdata = '0;
        endcase
    end

    assign ovf_flag = ovf_q;

    // R3
    hi_wr_temp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd1) |=> (temp_q == $past(bus_wdata)));

    // R2
    lo_rd_snap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 2'd0) |=> (temp_q == $past(count[CNT_W-1:BYTE_W])));

    // R10
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !(bus_wr && bus_addr == 2'd2 && bus_wdata[0])) |=> ovf_flag);

    // R9
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_evt |=> ovf_flag);

endmodule

// File: rtl/byte_updown_counter.sv
`timescale 1ns/1ps
module byte_updown_counter
    import cntr_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int SEL_W  = 3,
    parameter logic [(1<<SEL_W)-1:0] SEL_MASK = '1,
    localparam int CNT_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic [SEL_W-1:0]  clk_sel,
    input  logic              tick_en,
    input  logic              dir_down,
    input  logic              clr_req,
    input  logic [CNT_W-1:0]  top_val,
    output logic              at_top,
    output logic              at_bottom,
    output logic              ovf_flag
);
    logic             tick;
    logic             load;
    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] count;
    logic             wrap_evt;

    cntr_tick_sel #(
        .SEL_W    (SEL_W),
        .SEL_MASK (SEL_MASK)
    ) u_tick (
        .clk_sel (clk_sel),
        .tick_en (tick_en),
        .tick    (tick)
    );

    cntr_core #(
        .CNT_W (CNT_W)
    ) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .dir_down  (dir_down),
        .clr_req   (clr_req),
        .load      (load),
        .load_val  (load_val),
        .top_val   (top_val),
        .count     (count),
        .at_top    (at_top),
        .at_bottom (at_bottom),
        .wrap_evt  (wrap_evt)
    );

    cntr_byte_port #(
        .BYTE_W (BYTE_W)
    ) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .count     (count),
        .wrap_evt  (wrap_evt),
        .load      (load),
        .load_val  (load_val),
        .ovf_flag  (ovf_flag)
    );

    // R7
    sel_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel == '0 && !(bus_wr && bus_addr == 2'd0)) |=> (at_bottom == $past(at_bottom)));

endmodule

// File: tb/tb_byte_updown_counter.sv
`timescale 1ns/1ps
module tb_byte_updown_counter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [2:0]  clk_sel = '0;
    logic        tick_en = 1'b0;
    logic        dir_down = 1'b0;
    logic        clr_req = 1'b0;
    logic [15:0] top_val = 16'h00FF;
    logic        at_top;
    logic        at_bottom;
    logic        ovf_flag;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        string       req;
        logic [15:0] exp;
    } item_t;

    item_t       exp_q[$];
    logic [15:0] got_q[$];

    always #10 clk = ~clk;

    byte_updown_counter dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .clk_sel   (clk_sel),
        .tick_en   (tick_en),
        .dir_down  (dir_down),
        .clr_req   (clr_req),
        .top_val   (top_val),
        .at_top    (at_top),
        .at_bottom (at_bottom),
        .ovf_flag  (ovf_flag)
    );

    // Monitor: pairs each observed value with the oldest expected item.
    initial begin
        forever begin
            @(negedge clk);
            while (exp_q.size() > 0 && got_q.size() > 0) begin
                item_t       it;
                logic [15:0] g;
                it = exp_q.pop_front();
                g  = got_q.pop_front();
                checks++;
                if (g !== it.exp) begin
                    fails++;
                    $display("FAIL %s actual=%h expected=%h", it.req, g, it.exp);
                end
            end
        end
    end

    task automatic push_exp(input string req, input logic [15:0] e, input logic [15:0] g);
        item_t it;
        it.req = req;
        it.exp = e;
        exp_q.push_back(it);
        got_q.push_back(g);
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        bus_rd   = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd   = 1'b0;
    endtask

    task automatic expect_count(input string req, input logic [15:0] e);
        logic [7:0] lo;
        logic [7:0] hi;
        bus_read(2'd0, lo);
        bus_read(2'd1, hi);
        push_exp(req, e, {hi, lo});
    endtask

    task automatic expect_flags(input string req, input logic [2:0] e);
        #1 push_exp(req, {13'd0, e}, {13'd0, at_top, at_bottom, ovf_flag});
    endtask

    task automatic run_ticks(input logic [2:0] sel, input logic down, input int n);
        clk_sel  = sel;
        dir_down = down;
        tick_en  = 1'b1;
        repeat (n) @(negedge clk);
        tick_en  = 1'b0;
    endtask

    task automatic set_count(input logic [15:0] v);
        bus_write(2'd1, v[15:8]);
        bus_write(2'd0, v[7:0]);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] lo;
        logic [7:0] hi;
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        expect_flags("R1 flags after reset", 3'b010);
        expect_count("R1 count after reset", 16'h0000);

        // R3 / R2: high write reaches only the temporary register
        bus_write(2'd1, 8'h12);
        bus_read(2'd1, d);
        push_exp("R2 high read returns temporary", 16'h0012, {8'd0, d});
        bus_read(2'd0, d);
        push_exp("R3 counter unchanged by high write", 16'h0000, {8'd0, d});

        // R4: atomic 16-bit write
        set_count(16'h1234);
        expect_count("R4 low write commits both bytes", 16'h1234);
        expect_flags("R8 flags mid range", 3'b000);

        // R6: counting and clear
        run_ticks(3'd1, 1'b0, 5);
        expect_count("R6 up ticks", 16'h1239);
        run_ticks(3'd5, 1'b1, 2);
        expect_count("R6 down ticks", 16'h1237);
        clr_req = 1'b1;
        run_ticks(3'd7, 1'b1, 1);
        clr_req = 1'b0;
        expect_count("R6 clear beats direction", 16'h0000);

        // R7: code 0 holds the counter but bus still works
        set_count(16'h0050);
        run_ticks(3'd0, 1'b0, 4);
        expect_count("R7 hold with code 0", 16'h0050);
        set_count(16'h00FD);
        expect_count("R7 write while stopped", 16'h00FD);

        // R8 / R9 / R10: top, wraps and sticky flag
        run_ticks(3'd2, 1'b0, 2);
        expect_flags("R8 at top", 3'b100);
        run_ticks(3'd2, 1'b0, 1);
        expect_flags("R9 up wrap sets flag", 3'b011);
        run_ticks(3'd2, 1'b1, 1);
        expect_count("R9 down wrap to top", 16'h00FF);
        expect_flags("R9 down wrap no new flag", 3'b101);
        bus_read(2'd2, d);
        push_exp("R10 flag readable", 16'h0001, {8'd0, d});
        bus_write(2'd2, 8'hFE);
        expect_flags("R10 write 0 keeps flag", 3'b101);
        bus_write(2'd2, 8'h01);
        expect_flags("R10 write 1 clears flag", 3'b100);

        // R5: write beats clear and count
        bus_write(2'd1, 8'h40);
        clk_sel = 3'd1;
        tick_en = 1'b1;
        clr_req = 1'b1;
        bus_write(2'd0, 8'h10);
        tick_en = 1'b0;
        clr_req = 1'b0;
        expect_count("R5 write beats clear", 16'h4010);
        bus_write(2'd1, 8'h00);
        dir_down = 1'b0;
        tick_en  = 1'b1;
        bus_write(2'd0, 8'h05);
        tick_en  = 1'b0;
        expect_count("R5 write beats count", 16'h0005);

        // R2: atomic read while ticking
        top_val = 16'hFFFF;
        set_count(16'h01FF);
        clk_sel  = 3'd1;
        dir_down = 1'b0;
        tick_en  = 1'b1;
        bus_read(2'd0, lo);
        bus_read(2'd1, hi);
        tick_en  = 1'b0;
        push_exp("R2 snapshot across tick", 16'h01FF, {hi, lo});
        expect_count("R2 counter kept ticking", 16'h0201);

        // R10: set wins over clear in the same cycle
        top_val = 16'h00FF;
        set_count(16'h00FF);
        clk_sel  = 3'd1;
        dir_down = 1'b0;
        tick_en  = 1'b1;
        bus_write(2'd2, 8'h01);
        tick_en  = 1'b0;
        expect_flags("R10 set beats clear", 3'b011);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule